// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block holds the interrupt priority state of one hardware thread for two privilege rings: an operating-system ring and a hypervisor physical ring. Each ring keeps an 8-bit pending bitmap, a pending-priority register derived from that bitmap, a current-priority register written by software, and a status byte holding the exception flag. Priorities run from 0 (most favoured) to 7 (least favoured). A smaller number wins.

Each ring accepts three kinds of request. A post marks a priority as pending. A current-priority write sets the level below which interrupts are taken. An acknowledge takes the most favoured pending interrupt and returns a packed status word. Whenever a post or a current-priority write leaves a pending priority numerically below the current priority, the ring sets its exception flag and raises its own interrupt line. The interrupt line stays high until an acknowledge lowers it. All state updates happen on one clock edge. The acknowledge word appears on the next cycle, with a one-cycle valid strobe.

Top module: `thread_prio_ctx`

## Requirements
- R1: A post of priority p in 0..7 sets pending bit (7 - p). A post with p above 7 leaves the pending bitmap unchanged.
- R2: The pending-priority output equals the number of leading zeros of the 8-bit pending bitmap, counted from bit 7. It reads 0xFF when the bitmap is empty.
- R3: After a post or a current-priority write, the ring raises its exception and interrupt line if the pending priority is strictly below the current priority. Equal values raise nothing.
- R4: The OS ring sets status bit 7 (value 0x80) and drives `os_irq`. The hypervisor ring sets status bits 7:6 to code 01 (value 0x40) and drives `hv_irq`. Activity on one ring never changes the other ring's outputs.
- R5: A current-priority write is compared against the pending priority on the same edge that stores it.
- R6: An acknowledge always lowers the ring's interrupt line. If the exception flag is set, the acknowledge also does the following on the same edge:
  - copies the pending priority into the current priority;
  - clears that priority's pending bit;
  - recomputes the pending priority;
  - clears the exception flag.
- R7: One cycle after an acknowledge, `*_ack_vld` pulses for one cycle and `*_ack_data` carries {status before the acknowledge, current priority after it}, with the status in bits 15:8.
- R8: An acknowledge with no exception flag set leaves the current priority and the pending bitmap unchanged, and returns status 0x00.
- R9: Reset leaves the current priority at 0, the status at 0, the interrupt lines low and the pending priority at 0xFF. A first current-priority write of 0xFF with nothing pending therefore raises nothing.
- R10: When an acknowledge and a post reach the same ring in the same cycle, the acknowledge is applied first and the post second. The exception check then uses the post's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_post_vld | input | 1 | Post a priority to the OS ring |
| os_post_prio | input | 8 | Priority to post to the OS ring |
| os_cppr_wr | input | 1 | Write the OS current priority |
| os_cppr_data | input | 8 | New OS current priority |
| os_ack | input | 1 | Acknowledge on the OS ring |
| os_irq | output | 1 | OS interrupt line |
| os_pipr | output | 8 | OS pending priority |
| os_ack_vld | output | 1 | OS acknowledge result valid |
| os_ack_data | output | 16 | OS acknowledge word |
| hv_post_vld | input | 1 | Post a priority to the hypervisor ring |
| hv_post_prio | input | 8 | Priority to post to the hypervisor ring |
| hv_cppr_wr | input | 1 | Write the hypervisor current priority |
| hv_cppr_data | input | 8 | New hypervisor current priority |
| hv_ack | input | 1 | Acknowledge on the hypervisor ring |
| hv_irq | output | 1 | Hypervisor interrupt line |
| hv_pipr | output | 8 | Hypervisor pending priority |
| hv_ack_vld | output | 1 | Hypervisor acknowledge result valid |
| hv_ack_data | output | 16 | Hypervisor acknowledge word |

## Verification
A request driven in cycle N updates the pending priority and the interrupt line at the edge that ends cycle N. The bench drives inputs on a falling edge, removes them on the next falling edge, and reads those outputs at that second falling edge. The acknowledge word is registered at the same edge, so `*_ack_vld` is high in cycle N+1 and visible at that same falling edge. For this reason the driver pushes the expected word into a per-ring queue before the edge, and a monitor pops and compares the queue whenever a valid strobe is sampled.

// File: rtl/thread_prio_pkg.sv
package thread_prio_pkg;
  localparam int PRIO_BITS  = 8;
  localparam int PRIO_LVLS  = 8;
  localparam int STAT_BITS  = 8;
  localparam int ACK_BITS   = STAT_BITS + PRIO_BITS;
  localparam int NUM_RINGS  = 2;

  typedef enum logic [0:0] {RING_OS = 1'b0, RING_HV = 1'b1} ring_e;

  // exception field per ring: mask of the field and value written when raised
  localparam logic [STAT_BITS-1:0] OS_EXC_MASK = 8'h80;
  localparam logic [STAT_BITS-1:0] OS_EXC_SET  = 8'h80;
  localparam logic [STAT_BITS-1:0] HV_EXC_MASK = 8'hC0;
  localparam logic [STAT_BITS-1:0] HV_EXC_SET  = 8'h40;

  typedef struct packed {
    logic                 post_vld;
    logic [PRIO_BITS-1:0] post_prio;
    logic                 cppr_wr;
    logic [PRIO_BITS-1:0] cppr_data;
    logic                 ack;
  } ring_req_t;

  typedef struct packed {
    logic                 irq;
    logic [PRIO_BITS-1:0] pipr;
    logic                 ack_vld;
    logic [ACK_BITS-1:0]  ack_data;
  } ring_rsp_t;
endpackage

// File: rtl/prio_rst_sync.sv
module prio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/prio_ring.sv
module prio_ring
  import thread_prio_pkg::*;
#(
  parameter int                    LVLS     = PRIO_LVLS,
  parameter int                    PW       = PRIO_BITS,
  parameter int                    SW       = STAT_BITS,
  parameter logic [STAT_BITS-1:0]  EXC_MASK = OS_EXC_MASK,
  parameter logic [STAT_BITS-1:0]  EXC_SET  = OS_EXC_SET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_vld,
  input  logic [PW-1:0]    post_prio,
  input  logic             cppr_wr,
  input  logic [PW-1:0]    cppr_data,
  input  logic             ack,
  output logic             irq,
  output logic [PW-1:0]    pipr,
  output logic             ack_vld,
  output logic [SW+PW-1:0] ack_data
);
  localparam int MAXP = LVLS - 1;

  logic [LVLS-1:0]  ipb_q, ipb_n;
  logic [PW-1:0]    pipr_q, pipr_n;
  logic [PW-1:0]    cppr_q, cppr_n;
  logic [SW-1:0]    nsr_q, nsr_n;
  logic             irq_q, irq_n;
  logic             ack_vld_q;
  logic [SW+PW-1:0] word_q, word_n;
  logic             state_en;

  // one-hot pending bit for a priority; none when out of range
  function automatic logic [LVLS-1:0] prio_bit(input logic [PW-1:0] p);
    logic [LVLS-1:0] m;
    m = '0;
    for (int i = 0; i < LVLS; i++)
      if (p == PW'(i)) m[MAXP - i] = 1'b1;
    return m;
  endfunction

  // leading zero count from the top bit, all ones when empty
  function automatic logic [PW-1:0] best_prio(input logic [LVLS-1:0] v);
    logic [PW-1:0] r;
    r = '1;
    for (int i = 0; i < LVLS; i++)
      if (v[i]) r = PW'(MAXP - i);
    return r;
  endfunction

  assign state_en = post_vld | cppr_wr | ack;

  always_comb begin
    ipb_n  = ipb_q;
    cppr_n = cppr_q;
    nsr_n  = nsr_q;
    irq_n  = irq_q;
    word_n = word_q;
    // step 1: acknowledge
    if (ack) begin
      irq_n = 1'b0;
      if ((nsr_q & EXC_MASK) != '0) begin
        cppr_n = pipr_q;
        ipb_n  = ipb_q & ~prio_bit(pipr_q);
        nsr_n  = nsr_q & ~EXC_MASK;
      end
      word_n = {nsr_q, cppr_n};
    end
    // step 2: current priority write
    if (cppr_wr) cppr_n = cppr_data;
    // step 3: post
    if (post_vld) ipb_n = ipb_n | prio_bit(post_prio);
    pipr_n = best_prio(ipb_n);
    // step 4: exception check on post or priority write
    if ((post_vld || cppr_wr) && (pipr_n < cppr_n)) begin
      nsr_n = nsr_n | EXC_SET;
      irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipb_q  <= '0;
      pipr_q <= '1;
      cppr_q <= '0;
      nsr_q  <= '0;
      irq_q  <= 1'b0;
    end else if (state_en) begin
      ipb_q  <= ipb_n;
      pipr_q <= pipr_n;
      cppr_q <= cppr_n;
      nsr_q  <= nsr_n;
      irq_q  <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_q <= 1'b0;
      word_q    <= '0;
    end else begin
      ack_vld_q <= ack;
      if (ack) word_q <= word_n;
    end
  end

  assign irq      = irq_q;
  assign pipr     = pipr_q;
  assign ack_vld  = ack_vld_q;
  assign ack_data = word_q;
endmodule

// File: rtl/thread_prio_ctx.sv
module thread_prio_ctx
  import thread_prio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_post_vld,
  input  logic [7:0]  os_post_prio,
  input  logic        os_cppr_wr,
  input  logic [7:0]  os_cppr_data,
  input  logic        os_ack,
  output logic        os_irq,
  output logic [7:0]  os_pipr,
  output logic        os_ack_vld,
  output logic [15:0] os_ack_data,
  input  logic        hv_post_vld,
  input  logic [7:0]  hv_post_prio,
  input  logic        hv_cppr_wr,
  input  logic [7:0]  hv_cppr_data,
  input  logic        hv_ack,
  output logic        hv_irq,
  output logic [7:0]  hv_pipr,
  output logic        hv_ack_vld,
  output logic [15:0] hv_ack_data
);
  logic      rst_q_n;
  ring_req_t req [NUM_RINGS];
  ring_rsp_t rsp [NUM_RINGS];

  prio_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_q_n)
  );

  assign req[RING_OS] = '{post_vld: os_post_vld, post_prio: os_post_prio,
                          cppr_wr: os_cppr_wr, cppr_data: os_cppr_data, ack: os_ack};
  assign req[RING_HV] = '{post_vld: hv_post_vld, post_prio: hv_post_prio,
                          cppr_wr: hv_cppr_wr, cppr_data: hv_cppr_data, ack: hv_ack};

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    localparam logic [STAT_BITS-1:0] MSK = (g == int'(RING_HV)) ? HV_EXC_MASK : OS_EXC_MASK;
    localparam logic [STAT_BITS-1:0] SET = (g == int'(RING_HV)) ? HV_EXC_SET  : OS_EXC_SET;
    prio_ring #(
      .LVLS(PRIO_LVLS), .PW(PRIO_BITS), .SW(STAT_BITS),
      .EXC_MASK(MSK), .EXC_SET(SET)
    ) i_ring (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .post_vld  (req[g].post_vld),
      .post_prio (req[g].post_prio),
      .cppr_wr   (req[g].cppr_wr),
      .cppr_data (req[g].cppr_data),
      .ack       (req[g].ack),
      .irq       (rsp[g].irq),
      .pipr      (rsp[g].pipr),
      .ack_vld   (rsp[g].ack_vld),
      .ack_data  (rsp[g].ack_data)
    );
  end

  assign os_irq      = rsp[RING_OS].irq;
  assign os_pipr     = rsp[RING_OS].pipr;
  assign os_ack_vld  = rsp[RING_OS].ack_vld;
  assign os_ack_data = rsp[RING_OS].ack_data;
  assign hv_irq      = rsp[RING_HV].irq;
  assign hv_pipr     = rsp[RING_HV].pipr;
  assign hv_ack_vld  = rsp[RING_HV].ack_vld;
  assign hv_ack_data = rsp[RING_HV].ack_data;
endmodule

// File: rtl/thread_prio_ctx_chk.sv
module thread_prio_ctx_chk #(
  parameter int         MAXP = 7,
  parameter logic [7:0] MASK = 8'h80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        post,
  input logic        cppr_wr,
  input logic        ack,
  input logic        irq,
  input logic [7:0]  pipr,
  input logic        ack_vld,
  input logic [15:0] ack_data
);
  a_r1_pipr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!post && !ack) |=> $stable(pipr));

  a_r2_pipr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pipr == 8'hFF) || (pipr <= 8'(MAXP)));

  a_r3_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(post || cppr_wr));

  a_r6_ack_lowers_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !post && !cppr_wr) |=> !irq);

  a_r6_ack_takes_pipr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cppr_wr) |=> (((ack_data[15:8] & MASK) == 8'h00) || (ack_data[7:0] == $past(pipr))));

  a_r7_ack_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ack_vld);

  a_r7_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !ack_vld);
endmodule

bind thread_prio_ctx thread_prio_ctx_chk #(.MAXP(7), .MASK(8'h80)) i_chk_os (
  .clk(clk), .rst_n(rst_q_n), .post(os_post_vld), .cppr_wr(os_cppr_wr), .ack(os_ack),
  .irq(os_irq), .pipr(os_pipr), .ack_vld(os_ack_vld), .ack_data(os_ack_data));

bind thread_prio_ctx thread_prio_ctx_chk #(.MAXP(7), .MASK(8'hC0)) i_chk_hv (
  .clk(clk), .rst_n(rst_q_n), .post(hv_post_vld), .cppr_wr(hv_cppr_wr), .ack(hv_ack),
  .irq(hv_irq), .pipr(hv_pipr), .ack_vld(hv_ack_vld), .ack_data(hv_ack_data));

// File: tb/test_thread_prio_ctx.sv
module test_thread_prio_ctx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_post_vld, os_cppr_wr, os_ack;
  logic [7:0]  os_post_prio, os_cppr_data;
  logic        hv_post_vld, hv_cppr_wr, hv_ack;
  logic [7:0]  hv_post_prio, hv_cppr_data;
  logic        os_irq, hv_irq, os_ack_vld, hv_ack_vld;
  logic [7:0]  os_pipr, hv_pipr;
  logic [15:0] os_ack_data, hv_ack_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;
  logic [15:0] os_q[$];
  logic [15:0] hv_q[$];

  always #2.5 clk = ~clk;

  thread_prio_ctx i_thread_prio_ctx (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request cycle on ring r (0 = OS, 1 = HV)
  task automatic step(input bit r, input bit post, input logic [7:0] pp,
                      input bit cw, input logic [7:0] cd, input bit ack,
                      input logic [15:0] exp_word);
    @(negedge clk);
    if (r == 1'b0) begin
      os_post_vld = post; os_post_prio = pp; os_cppr_wr = cw; os_cppr_data = cd; os_ack = ack;
      if (ack) os_q.push_back(exp_word);
    end else begin
      hv_post_vld = post; hv_post_prio = pp; hv_cppr_wr = cw; hv_cppr_data = cd; hv_ack = ack;
      if (ack) hv_q.push_back(exp_word);
    end
    @(negedge clk);
    os_post_vld = 0; os_cppr_wr = 0; os_ack = 0;
    hv_post_vld = 0; hv_cppr_wr = 0; hv_ack = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (os_ack_vld) begin
      if (os_q.size() == 0) chk("R7 os unexpected ack", os_ack_data, 16'hxxxx);
      else chk("R7 os ack word", os_ack_data, os_q.pop_front());
    end
    if (hv_ack_vld) begin
      if (hv_q.size() == 0) chk("R7 hv unexpected ack", hv_ack_data, 16'hxxxx);
      else chk("R7 hv ack word", hv_ack_data, hv_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    os_post_vld = 0; os_cppr_wr = 0; os_ack = 0; os_post_prio = 0; os_cppr_data = 0;
    hv_post_vld = 0; hv_cppr_wr = 0; hv_ack = 0; hv_post_prio = 0; hv_cppr_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 os pipr reset", 16'(os_pipr), 16'h00FF);
    chk("R9 hv pipr reset", 16'(hv_pipr), 16'h00FF);
    chk("R9 os irq reset", 16'(os_irq), 16'h0);
    chk("R9 hv irq reset", 16'(hv_irq), 16'h0);

    // OS ring
    step(0, 1, 8'd3, 0, 0, 0, 0);
    chk("R1 os pipr post 3", 16'(os_pipr), 16'h0003);
    chk("R3 os no irq cppr 0", 16'(os_irq), 16'h0);
    step(0, 0, 0, 1, 8'hFF, 0, 0);
    chk("R5 os irq after cppr write", 16'(os_irq), 16'h1);
    chk("R4 hv untouched", 16'(hv_irq), 16'h0);
    step(0, 1, 8'd1, 0, 0, 0, 0);
    chk("R2 os pipr best of 1,3", 16'(os_pipr), 16'h0001);
    step(0, 0, 0, 0, 0, 1, 16'h8001);
    chk("R6 os irq lowered", 16'(os_irq), 16'h0);
    chk("R6 os pipr recomputed", 16'(os_pipr), 16'h0003);
    step(0, 0, 0, 0, 0, 1, 16'h0001);       // R8 no exception pending
    chk("R8 os pipr unchanged", 16'(os_pipr), 16'h0003);
    step(0, 1, 8'd9, 0, 0, 0, 0);
    chk("R1 os post above max ignored", 16'(os_pipr), 16'h0003);
    chk("R1 os no irq post 9", 16'(os_irq), 16'h0);
    step(0, 1, 8'd0, 0, 0, 0, 0);
    chk("R3 os irq post 0 below cppr 1", 16'(os_irq), 16'h1);
    step(0, 1, 8'd2, 0, 0, 1, 16'h8000);    // R10 ack then post
    chk("R10 os irq after ack+post", 16'(os_irq), 16'h0);
    chk("R10 os pipr after ack+post", 16'(os_pipr), 16'h0002);
    step(0, 0, 0, 1, 8'hFF, 0, 0);
    chk("R5 os irq cppr FF", 16'(os_irq), 16'h1);
    step(0, 0, 0, 0, 0, 1, 16'h8002);
    chk("R6 os pipr after ack", 16'(os_pipr), 16'h0003);
    step(0, 0, 0, 1, 8'd3, 0, 0);
    chk("R3 os equal no irq", 16'(os_irq), 16'h0);
    step(0, 0, 0, 1, 8'd4, 0, 0);
    chk("R5 os irq cppr 4", 16'(os_irq), 16'h1);
    step(0, 0, 0, 0, 0, 1, 16'h8003);
    chk("R2 os pipr empty", 16'(os_pipr), 16'h00FF);
    step(0, 0, 0, 0, 0, 1, 16'h0003);       // R8 second ack
    step(0, 0, 0, 1, 8'hFF, 0, 0);
    chk("R9 os no spurious irq", 16'(os_irq), 16'h0);

    // HV ring
    step(1, 0, 0, 1, 8'hFF, 0, 0);
    chk("R9 hv no spurious irq", 16'(hv_irq), 16'h0);
    step(1, 1, 8'd7, 0, 0, 0, 0);
    chk("R4 hv irq post 7", 16'(hv_irq), 16'h1);
    chk("R1 hv pipr 7", 16'(hv_pipr), 16'h0007);
    chk("R4 os isolated", 16'(os_irq), 16'h0);
    step(1, 0, 0, 0, 0, 1, 16'h4007);       // R4 status 0x40
    chk("R6 hv pipr empty", 16'(hv_pipr), 16'h00FF);
    chk("R6 hv irq low", 16'(hv_irq), 16'h0);
    step(1, 1, 8'd8, 0, 0, 0, 0);
    chk("R1 hv post 8 ignored", 16'(hv_pipr), 16'h00FF);
    step(1, 1, 8'd5, 0, 0, 0, 0);
    chk("R3 hv irq 5 below 7", 16'(hv_irq), 16'h1);
    step(1, 0, 0, 0, 0, 1, 16'h4005);

    repeat (3) @(negedge clk);
    chk("R7 os queue drained", 16'(os_q.size()), 16'h0);
    chk("R7 hv queue drained", 16'(hv_q.size()), 16'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule